// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Tuner

This block keeps a tunable oscillator on frequency by trimming its fine adjust code against a slow, trusted reference tick. A 1 kHz USB start-of-frame pulse is a typical reference. The block runs in the oscillator's own clock domain. It measures how many of its clock cycles fit between two consecutive reference ticks and compares that figure with a programmed ratio, the target frequency divided by the reference rate. For example, a 48 MHz target with a 1 kHz reference uses 48000. With a 1.024 kHz reference the same target uses 46875. After each measured interval the code moves at most one step, toward the target.

The host cannot always be trusted to keep sending ticks. When the bus goes quiet for a set number of cycles (3 ms of the controlled clock), the loop freezes the code instead of chasing a reference that has stopped. Software may load the code only while the loop is disabled, and the loop resumes from the loaded value. A controller in four states manages this:

- OFF: disabled. Software writes are accepted here.
- ALIGN: waits for the first tick, which opens an interval.
- TRACK: measures each interval and adjusts the code.
- SUSPEND: frozen.

The transitions are:

- Dropping `enable` sends any state to OFF.
- OFF goes to ALIGN when `enable` is set.
- ALIGN goes to TRACK on a tick.
- ALIGN or TRACK goes to SUSPEND when the idle timer expires and no tick arrives in that cycle.
- SUSPEND goes to TRACK on a tick, and that tick opens a new interval.
- SUSPEND goes to ALIGN on a bus-activity strobe.

Top module: `dfll_tuner`

## Requirements
- R1: After reset `fine_code` is 0x40, and `stat_enabled`, `stat_suspended` and `stat_locked` are all low.
- R2: In TRACK, each tick measures the number of clock cycles since the previous tick (ticks P cycles apart measure P; the count saturates at 65535). A measurement above `compare` lowers `fine_code` by one, and a measurement below raises it by one. The code changes at no other time while the loop is enabled.
- R3: A measurement equal to `compare` leaves `fine_code` unchanged.
- R4: `fine_code` stays within 1 to 127 and never wraps. A software write of 0 loads 1.
- R5: A pulse on `sw_wr` loads `sw_code` only while `stat_enabled` is low, and that value is kept when the loop is enabled again. While `stat_enabled` is high the pulse has no effect.
- R6: The first tick after enable (ALIGN) or after leaving SUSPEND on a tick only opens an interval. It never adjusts the code.
- R7: After IDLE_CYCLES cycles with neither a `bus_act` strobe nor a tick, ALIGN or TRACK moves to SUSPEND. There `stat_suspended` is high, `stat_locked` is low and `fine_code` is frozen. Strobes of `bus_act` at shorter spacing prevent suspend.
- R8: In SUSPEND a tick resumes tracking directly. A `bus_act` strobe moves to ALIGN, which clears `stat_suspended`.
- R9: `stat_locked` rises after three consecutive equal measurements in TRACK. It falls on an unequal measurement or on leaving TRACK.
- R10: When a tick arrives in the same cycle that the idle timer expires, the tick wins. The interval is measured, and the block does not suspend.
- R11: `stat_enabled` is high in every state except OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controlled oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference tick, asynchronous; its rising edge marks an interval boundary |
| bus_act | input | 1 | Bus-activity strobe, synchronous to clk |
| enable | input | 1 | Loop enable |
| compare | input | 16 | Expected clock cycles per reference interval |
| sw_wr | input | 1 | Software write strobe for the fine code |
| sw_code | input | 7 | Value for a software write |
| fine_code | output | 7 | Fine frequency-adjust code |
| stat_enabled | output | 1 | Loop enabled (state is not OFF) |
| stat_suspended | output | 1 | Loop frozen by bus idle |
| stat_locked | output | 1 | Three consecutive equal measurements |

## Verification
Two functions can land in the same cycle: the idle timer reaching its limit and a synchronised reference tick. The bench provokes the collision by spacing ticks exactly one cycle beyond the idle limit, with `compare` set just below that spacing. If the code falls by one on every tick, the tick won. When the spacing is one cycle longer, the timer expires first and each tick only resumes the loop, so the code must not move at all even though every interval reads high. The sharp difference between those two spacings is the verdict.

// File: rtl/dfll_pkg.sv
package dfll_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ALIGN,
        ST_TRACK,
        ST_SUSPEND
    } dfll_state_e;

endpackage

// File: rtl/dfll_ref_sync.sv
module dfll_ref_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_pulse
);

    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= tick_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign tick_pulse = sync_q & ~prev_q;

endmodule

// File: rtl/dfll_idle_timer.sv
module dfll_idle_timer #(
    parameter int IDLE_CYCLES = 144000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic activity,
    output logic expired
);

    localparam int TW = $clog2(IDLE_CYCLES + 1);
    localparam logic [TW-1:0] LIMIT = TW'(IDLE_CYCLES);

    logic [TW-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (!run || activity) begin
            idle_q <= '0;
        end else if (idle_q != LIMIT) begin
            idle_q <= idle_q + TW'(1);
        end
    end

    assign expired = (idle_q == LIMIT);

endmodule

// File: rtl/dfll_period_counter.sv
module dfll_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear || !run) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dfll_tuner.sv
module dfll_tuner
    import dfll_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int CODE_W      = 7,
    parameter int IDLE_CYCLES = 144000,
    parameter int LOCK_RUN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_act,
    input  logic              enable,
    input  logic [CNT_W-1:0]  compare,
    input  logic              sw_wr,
    input  logic [CODE_W-1:0] sw_code,
    output logic [CODE_W-1:0] fine_code,
    output logic              stat_enabled,
    output logic              stat_suspended,
    output logic              stat_locked
);

    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_MIN = CODE_W'(1);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam int                RUN_W    = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0]  RUN_FULL = RUN_W'(LOCK_RUN);

    dfll_state_e state_q, state_d;
    logic              ref_pulse;
    logic              idle_expired;
    logic [CNT_W-1:0]  period_cnt;
    logic [CNT_W:0]    measured;
    logic [CNT_W:0]    target;
    logic [RUN_W-1:0]  eq_run_q;
    logic [CODE_W-1:0] code_q;

    dfll_ref_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (ref_tick),
        .tick_pulse (ref_pulse)
    );

    dfll_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      ((state_q == ST_ALIGN) || (state_q == ST_TRACK)),
        .activity (bus_act || ref_pulse),
        .expired  (idle_expired)
    );

    dfll_period_counter #(.CNT_W(CNT_W)) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_TRACK),
        .clear (ref_pulse),
        .count (period_cnt)
    );

    // Cycles since the previous tick, counting the tick cycle itself
    assign measured = {1'b0, period_cnt} + (CNT_W + 1)'(1);
    assign target   = {1'b0, compare};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_ALIGN;
                ST_ALIGN: begin
                    if (ref_pulse)         state_d = ST_TRACK;
                    else if (idle_expired) state_d = ST_SUSPEND;
                end
                ST_TRACK: begin
                    if (!ref_pulse && idle_expired) state_d = ST_SUSPEND;
                end
                ST_SUSPEND: begin
                    if (ref_pulse)    state_d = ST_TRACK;
                    else if (bus_act) state_d = ST_ALIGN;
                end
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // Output process: fine code and lock run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= CODE_MID;
            eq_run_q <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    eq_run_q <= '0;
                    if (sw_wr) begin
                        code_q <= (sw_code == '0) ? CODE_MIN : sw_code;
                    end
                end
                ST_TRACK: begin
                    if (ref_pulse) begin
                        if (measured > target) begin
                            eq_run_q <= '0;
                            if (code_q != CODE_MIN) code_q <= code_q - CODE_W'(1);
                        end else if (measured < target) begin
                            eq_run_q <= '0;
                            if (code_q != CODE_MAX) code_q <= code_q + CODE_W'(1);
                        end else if (eq_run_q != RUN_FULL) begin
                            eq_run_q <= eq_run_q + RUN_W'(1);
                        end
                    end
                end
                default: eq_run_q <= '0;
            endcase
        end
    end

    assign fine_code      = code_q;
    assign stat_enabled   = (state_q != ST_OFF);
    assign stat_suspended = (state_q == ST_SUSPEND);
    assign stat_locked    = (state_q == ST_TRACK) && (eq_run_q == RUN_FULL);

endmodule

// File: rtl/dfll_tuner_chk.sv
module dfll_tuner_chk #(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_pulse,
    input logic              sw_wr,
    input logic [CODE_W-1:0] fine_code,
    input logic              stat_enabled,
    input logic              stat_suspended,
    input logic              stat_locked
);

    AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fine_code != '0); // R4

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        stat_enabled |=> (fine_code == $past(fine_code)) ||
                         (fine_code == $past(fine_code) + CODE_W'(1)) ||
                         (fine_code == $past(fine_code) - CODE_W'(1))); // R2

    AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_enabled && !ref_pulse) |=> $stable(fine_code)); // R2

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_enabled && !sw_wr) |=> $stable(fine_code)); // R5

    AST_SUSPEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_suspended && $past(stat_suspended)) |-> $stable(fine_code)); // R7

    AST_LOCK_TRACKING: assert property (@(posedge clk) disable iff (!rst_n)
        stat_locked |-> (stat_enabled && !stat_suspended)); // R9

    AST_SUSPEND_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        stat_suspended |-> stat_enabled); // R11

endmodule

bind dfll_tuner dfll_tuner_chk #(.CODE_W(CODE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ref_pulse      (ref_pulse),
    .sw_wr          (sw_wr),
    .fine_code      (fine_code),
    .stat_enabled   (stat_enabled),
    .stat_suspended (stat_suspended),
    .stat_locked    (stat_locked)
);

// File: tb/test_dfll_tuner.sv
module test_dfll_tuner;

    localparam int IDLE = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_act = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] compare = 16'd40;
    logic        sw_wr = 1'b0;
    logic [6:0]  sw_code = '0;
    logic [6:0]  fine_code;
    logic        stat_enabled, stat_suspended, stat_locked;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dfll_tuner #(.IDLE_CYCLES(IDLE)) i_dfll_tuner (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_tick       (ref_tick),
        .bus_act        (bus_act),
        .enable         (enable),
        .compare        (compare),
        .sw_wr          (sw_wr),
        .sw_code        (sw_code),
        .fine_code      (fine_code),
        .stat_enabled   (stat_enabled),
        .stat_suspended (stat_suspended),
        .stat_locked    (stat_locked)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one tick, next tick may follow p cycles later
    task automatic tick(input int p);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        repeat (p - 1) @(negedge clk);
    endtask

    task automatic restart(input logic [6:0] start);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        sw_code = start;
        sw_wr = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0;
        enable = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic int step(input int cur, input int p, input int cmp);
        if (p > cmp) return (cur > 1) ? cur - 1 : 1;
        if (p < cmp) return (cur < 127) ? cur + 1 : 127;
        return cur;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int expv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fine_code, 64, "R1 reset code");
        check(stat_enabled, 0, "R1 reset enabled");
        check(stat_suspended, 0, "R1 reset suspended");
        check(stat_locked, 0, "R1 reset locked");

        // sweep of periods around compare = 40
        compare = 16'd40;
        for (int p = 36; p <= 44; p++) begin
            restart(7'h40);
            check(stat_enabled, 1, "R11 enabled flag");
            expv = 64;
            tick(p);
            check(fine_code, expv, $sformatf("R6 first tick p=%0d", p));
            for (int k = 0; k < 4; k++) begin
                tick(p);
                expv = step(expv, p, 40);
                check(fine_code, expv, $sformatf("%s p=%0d k=%0d", (p == 40) ? "R3" : "R2", p, k));
                if (p == 40) check(stat_locked, (k >= 2) ? 1 : 0, $sformatf("R9 lock k=%0d", k));
            end
            if (p == 40) begin
                sw_code = 7'h05;
                sw_wr = 1'b1;
                @(negedge clk);
                sw_wr = 1'b0;
                @(negedge clk);
                check(fine_code, 64, "R5 write ignored while enabled");
                tick(41);
                check(stat_locked, 0, "R9 lock drops on unequal");
                check(fine_code, 63, "R2 decrement after lock");
            end
        end

        // saturation
        restart(7'd126);
        expv = 126;
        tick(30);
        for (int k = 0; k < 4; k++) begin
            tick(30);
            expv = step(expv, 30, 40);
            check(fine_code, expv, "R4 upper clamp");
        end
        restart(7'd2);
        expv = 2;
        tick(50);
        for (int k = 0; k < 4; k++) begin
            tick(50);
            expv = step(expv, 50, 40);
            check(fine_code, expv, "R4 lower clamp");
        end
        restart(7'd0);
        check(fine_code, 1, "R4 write zero loads one");

        // written value kept across enable
        restart(7'h22);
        repeat (10) @(negedge clk);
        check(fine_code, 34, "R5 value kept on enable");

        // large counts
        compare = 16'd2000;
        for (int s = 0; s < 2; s++) begin
            int p;
            p = (s == 0) ? 1999 : 2001;
            restart(7'h40);
            expv = 64;
            tick(p);
            for (int k = 0; k < 3; k++) begin
                tick(p);
                expv = step(expv, p, 2000);
                check(fine_code, expv, $sformatf("R2 long interval p=%0d", p));
            end
        end

        // suspend and resume
        compare = 16'd40;
        restart(7'h40);
        tick(40); tick(40); tick(40);
        repeat (IDLE + 5) @(negedge clk);
        check(stat_suspended, 1, "R7 suspended after idle");
        check(stat_locked, 0, "R7 lock low in suspend");
        check(fine_code, 64, "R7 code frozen");
        bus_act = 1'b1;
        @(negedge clk);
        bus_act = 1'b0;
        @(negedge clk);
        check(stat_suspended, 0, "R8 bus activity leaves suspend");
        check(stat_enabled, 1, "R8 still enabled");
        repeat (IDLE + 5) @(negedge clk);
        check(stat_suspended, 1, "R7 suspended again");
        tick(45);
        check(stat_suspended, 0, "R8 tick resumes");
        check(fine_code, 64, "R6 resume tick only opens interval");
        tick(45);
        check(fine_code, 63, "R8 tracking after resume");
        for (int k = 0; k < 8; k++) begin
            bus_act = 1'b1;
            @(negedge clk);
            bus_act = 1'b0;
            repeat (499) @(negedge clk);
        end
        check(stat_suspended, 0, "R7 activity holds off suspend");
        tick(40);
        check(fine_code, 62, "R2 long gap measured high");

        // tick and idle expiry in one cycle
        compare = 16'(IDLE);
        restart(7'h40);
        expv = 64;
        tick(IDLE + 1);
        for (int k = 0; k < 3; k++) begin
            tick(IDLE + 1);
            expv = step(expv, IDLE + 1, IDLE);
            check(fine_code, expv, "R10 tick wins over expiry");
            check(stat_suspended, 0, "R10 no suspend on collision");
        end
        restart(7'h40);
        for (int k = 0; k < 4; k++) begin
            tick(IDLE + 2);
            check(fine_code, 64, "R10 expiry first freezes code");
        end

        finish_run();
    end

endmodule